// File: doc/BRIEF.md
# Strided Stream Prefetch Controller

This block runs four independent prefetch streams that software starts and then leaves alone. Each stream walks a region of memory from a start address at a programmable byte stride. It offers one cache-line fetch request per step until the region's byte count is used up. Requests go out only in cycles where the memory bus reports itself idle, so demand traffic always takes priority. Fetching is speculative: a stream can be stopped or replaced at any point without any error.

A single command port starts a stream, stops one stream, or stops all four at once. A start command carries the channel number, the start address, the byte count, the stride, a transient flag (lines may be discarded early) and a store-intent flag (fetch for write). On the fetch side, each request is tagged with its channel number and with the stream's two attribute bits. The request address is aligned down to a line boundary. When several streams are ready in the same idle cycle, a round-robin arbiter picks one. Each channel has a busy bit that clears once its byte counter reaches zero.

Top module: `stream_prefetch_ctrl`

## Requirements
- R1: After reset every busy bit is 0 and `req_o` is 0.
- R2: `req_o` is 1 only in cycles where `bus_idle_i` is 1. While `bus_idle_i` is 0, no request is offered, even if channels are busy.
- R3: A channel's first request address is its start address with the low 5 bits cleared (32-byte lines). Each granted request advances the channel's unaligned address by the stride, and the next request is that address with the low 5 bits cleared. Addresses wrap modulo 2^32.
- R4: A channel issues ceil(S/32) granted requests and then its busy bit clears. S is the commanded size, limited to 131072 bytes. A start with size 0 leaves the channel idle.
- R5: Every request carries `req_ch_o`, the issuing channel, and that channel's transient and store-intent flags as given at its start command.
- R6: Among busy channels in an idle cycle, the arbiter grants the first busy channel at or after the one following the last granted channel, in ascending channel order with wrap-around. After reset, the search starts at channel 0.
- R7: Command encoding on `cmd_op_i`: 0 = none, 1 = start, 2 = stop channel `cmd_ch_i`, 3 = stop all. A stop clears the named channel's busy bit at the next edge and leaves the other channels unchanged.
- R8: A stop-all clears all four busy bits at the same edge.
- R9: A start to a busy channel discards its current stream. The next request from that channel uses the new start address, and the channel completes the new size.
- R10: While a request is offered but not granted and no command arrives, the same channel and address are offered again in the next cycle if a request is offered at all.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_op_i | input | 2 | Command code (none/start/stop/stop all) |
| cmd_ch_i | input | 2 | Target channel |
| cmd_addr_i | input | 32 | Stream start address |
| cmd_size_i | input | 18 | Bytes to fetch (limited to 131072) |
| cmd_stride_i | input | 16 | Byte distance between requests |
| cmd_transient_i | input | 1 | Mark stream lines as discardable |
| cmd_store_i | input | 1 | Mark requests as fetch-for-write |
| bus_idle_i | input | 1 | Memory bus has no demand access this cycle |
| req_o | output | 1 | Prefetch request valid |
| req_addr_o | output | 32 | Line-aligned request address |
| req_ch_o | output | 2 | Channel issuing the request |
| req_transient_o | output | 1 | Transient attribute of the request |
| req_store_o | output | 1 | Store-intent attribute of the request |
| gnt_i | input | 1 | Request accepted this cycle |
| busy_o | output | 4 | Per-channel busy |

## Verification
The bench targets four corner cases:
- Unaligned start addresses, and a stream that wraps past the top of the address space. An alignment or adder slip would emit wrong line addresses.
- Sizes that are not a multiple of the line, a size of zero, and an oversized request that must be limited to 4096 lines. An off-by-one counter would emit one fetch too many or too few, or would never go idle.
- Four streams contending at once. A fixed-priority arbiter would starve the high channels instead of rotating 0,1,2,3.
- Restart, stop and stop-all on live streams. A design that missed these would keep fetching from the old region or leave stopped channels busy.

// File: rtl/spf_pkg.sv
package spf_pkg;
  typedef enum logic [1:0] {
    SPF_NOP      = 2'd0,
    SPF_START    = 2'd1,
    SPF_STOP     = 2'd2,
    SPF_STOP_ALL = 2'd3
  } spf_op_e;
endpackage

// File: rtl/spf_channel.sv
module spf_channel #(
  parameter int ADDR_W     = 32,
  parameter int SIZE_W     = 18,
  parameter int STRIDE_W   = 16,
  parameter int LINE_BYTES = 32,
  parameter int MAX_BYTES  = 131072
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic                stop_i,
  input  logic                adv_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [SIZE_W-1:0]   size_i,
  input  logic [STRIDE_W-1:0] stride_i,
  input  logic                transient_i,
  input  logic                store_i,
  output logic                busy_o,
  output logic [ADDR_W-1:0]   addr_o,
  output logic                transient_o,
  output logic                store_o
);
  localparam int LINE_W = $clog2(LINE_BYTES);
  localparam logic [SIZE_W-1:0] LINE_SZ = SIZE_W'(LINE_BYTES);
  localparam logic [SIZE_W-1:0] MAX_SZ  = SIZE_W'(MAX_BYTES);

  logic [ADDR_W-1:0]   cur_q;
  logic [SIZE_W-1:0]   rem_q;
  logic [STRIDE_W-1:0] stride_q;
  logic                tr_q, st_q;
  logic [SIZE_W-1:0]   size_lim;

  assign size_lim = (size_i > MAX_SZ) ? MAX_SZ : size_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q    <= '0;
      rem_q    <= '0;
      stride_q <= '0;
      tr_q     <= 1'b0;
      st_q     <= 1'b0;
    end else if (start_i) begin
      cur_q    <= addr_i;
      rem_q    <= size_lim;
      stride_q <= stride_i;
      tr_q     <= transient_i;
      st_q     <= store_i;
    end else if (stop_i) begin
      rem_q <= '0;
    end else if (adv_i && busy_o) begin
      cur_q <= cur_q + ADDR_W'(stride_q);
      rem_q <= (rem_q <= LINE_SZ) ? '0 : rem_q - LINE_SZ;
    end
  end

  assign busy_o      = (rem_q != '0);
  assign addr_o      = {cur_q[ADDR_W-1:LINE_W], {LINE_W{1'b0}}};
  assign transient_o = tr_q;
  assign store_o     = st_q;
endmodule

// File: rtl/spf_rr_arb.sv
module spf_rr_arb #(
  parameter int N     = 4,
  parameter int IDX_W = $clog2(N)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N-1:0]     req_i,
  input  logic             accept_i,
  output logic [N-1:0]     gnt_oh_o,
  output logic [IDX_W-1:0] idx_o
);
  logic [IDX_W-1:0] ptr_q;
  logic             found;

  // N is a power of two: index arithmetic wraps naturally
  always_comb begin
    gnt_oh_o = '0;
    idx_o    = '0;
    found    = 1'b0;
    for (int off = 0; off < N; off++) begin
      if (!found && req_i[ptr_q + IDX_W'(off)]) begin
        found                        = 1'b1;
        gnt_oh_o[ptr_q + IDX_W'(off)] = 1'b1;
        idx_o                        = ptr_q + IDX_W'(off);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                ptr_q <= '0;
    else if (accept_i && found) ptr_q <= idx_o + IDX_W'(1);
  end
endmodule

// File: rtl/stream_prefetch_ctrl.sv
module stream_prefetch_ctrl #(
  parameter int NUM_CH     = 4,
  parameter int ADDR_W     = 32,
  parameter int SIZE_W     = 18,
  parameter int STRIDE_W   = 16,
  parameter int LINE_BYTES = 32,
  parameter int MAX_BYTES  = 131072,
  localparam int CH_W      = $clog2(NUM_CH)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cmd_valid_i,
  input  logic [1:0]          cmd_op_i,
  input  logic [CH_W-1:0]     cmd_ch_i,
  input  logic [ADDR_W-1:0]   cmd_addr_i,
  input  logic [SIZE_W-1:0]   cmd_size_i,
  input  logic [STRIDE_W-1:0] cmd_stride_i,
  input  logic                cmd_transient_i,
  input  logic                cmd_store_i,
  input  logic                bus_idle_i,
  output logic                req_o,
  output logic [ADDR_W-1:0]   req_addr_o,
  output logic [CH_W-1:0]     req_ch_o,
  output logic                req_transient_o,
  output logic                req_store_o,
  input  logic                gnt_i,
  output logic [NUM_CH-1:0]   busy_o
);
  import spf_pkg::*;

  spf_op_e           op;
  logic [NUM_CH-1:0] ch_start, ch_stop, ch_adv, arb_req, arb_oh;
  logic [NUM_CH-1:0] ch_tr, ch_st;
  logic [ADDR_W-1:0] ch_addr [NUM_CH];
  logic [CH_W-1:0]   arb_idx;

  assign op = spf_op_e'(cmd_op_i);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    assign ch_start[g] = cmd_valid_i && op == SPF_START && cmd_ch_i == CH_W'(g);
    assign ch_stop[g]  = cmd_valid_i && ((op == SPF_STOP && cmd_ch_i == CH_W'(g)) ||
                                         op == SPF_STOP_ALL);
    assign ch_adv[g]   = arb_oh[g] & gnt_i;

    spf_channel #(
      .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .STRIDE_W(STRIDE_W),
      .LINE_BYTES(LINE_BYTES), .MAX_BYTES(MAX_BYTES)
    ) u_ch (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .start_i    (ch_start[g]),
      .stop_i     (ch_stop[g]),
      .adv_i      (ch_adv[g]),
      .addr_i     (cmd_addr_i),
      .size_i     (cmd_size_i),
      .stride_i   (cmd_stride_i),
      .transient_i(cmd_transient_i),
      .store_i    (cmd_store_i),
      .busy_o     (busy_o[g]),
      .addr_o     (ch_addr[g]),
      .transient_o(ch_tr[g]),
      .store_o    (ch_st[g])
    );
  end

  // demand traffic owns non-idle cycles
  assign arb_req = busy_o & {NUM_CH{bus_idle_i}};

  spf_rr_arb #(.N(NUM_CH), .IDX_W(CH_W)) u_arb (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (arb_req),
    .accept_i(gnt_i),
    .gnt_oh_o(arb_oh),
    .idx_o   (arb_idx)
  );

  assign req_o           = |arb_req;
  assign req_ch_o        = arb_idx;
  assign req_addr_o      = ch_addr[arb_idx];
  assign req_transient_o = ch_tr[arb_idx];
  assign req_store_o     = ch_st[arb_idx];
endmodule

// File: rtl/spf_checker.sv
module spf_checker #(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 32,
  parameter int CH_W   = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cmd_valid_i,
  input logic [1:0]        cmd_op_i,
  input logic [CH_W-1:0]   cmd_ch_i,
  input logic              bus_idle_i,
  input logic              req_o,
  input logic [ADDR_W-1:0] req_addr_o,
  input logic [CH_W-1:0]   req_ch_o,
  input logic              gnt_i,
  input logic [NUM_CH-1:0] busy_o
);
  // R2
  idle_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> bus_idle_i);

  // R5
  req_from_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> busy_o[req_ch_o]);

  // R8
  stop_all_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_op_i == 2'd3) |=> (busy_o == '0));

  // R7
  stop_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_op_i == 2'd2) |=> !busy_o[$past(cmd_ch_i)]);

  // R10
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !gnt_i && !cmd_valid_i) |=>
      (!req_o || ($stable(req_addr_o) && $stable(req_ch_o))));

  // R2
  no_req_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_idle_i && busy_o != '0) |-> req_o);
endmodule

bind stream_prefetch_ctrl spf_checker #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .CH_W(CH_W)) u_spf_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cmd_valid_i(cmd_valid_i),
  .cmd_op_i   (cmd_op_i),
  .cmd_ch_i   (cmd_ch_i),
  .bus_idle_i (bus_idle_i),
  .req_o      (req_o),
  .req_addr_o (req_addr_o),
  .req_ch_o   (req_ch_o),
  .gnt_i      (gnt_i),
  .busy_o     (busy_o)
);

// File: tb/stream_prefetch_ctrl_bench.sv
module stream_prefetch_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 4;
  // {addr, size, stride, channel}
  localparam logic [31:0] V_ADDR   [NV] = '{32'h1000_0013, 32'h2000_0000, 32'h0000_0FF0, 32'hFFFF_FFE0};
  localparam logic [17:0] V_SIZE   [NV] = '{18'd100, 18'd32, 18'd257, 18'd96};
  localparam logic [15:0] V_STRIDE [NV] = '{16'd40, 16'd64, 16'd32, 16'd16};
  localparam logic [1:0]  V_CH     [NV] = '{2'd0, 2'd1, 2'd2, 2'd3};

  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0, cmd_tr = 0, cmd_st = 0, bus_idle = 0, gnt = 0;
  logic [1:0] cmd_op = 0, cmd_ch = 0;
  logic [31:0] cmd_addr = 0;
  logic [17:0] cmd_size = 0;
  logic [15:0] cmd_stride = 0;
  logic req, req_tr, req_st;
  logic [31:0] req_addr;
  logic [1:0] req_ch;
  logic [3:0] busy;

  int n_chk = 0, n_bad = 0, cyc = 0;
  logic s_req, s_tr, s_st;
  logic [31:0] s_addr;
  logic [1:0] s_ch;

  always #(CLK_PERIOD/2) clk = ~clk;

  stream_prefetch_ctrl u_stream_prefetch_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op),
    .cmd_ch_i(cmd_ch), .cmd_addr_i(cmd_addr), .cmd_size_i(cmd_size),
    .cmd_stride_i(cmd_stride), .cmd_transient_i(cmd_tr), .cmd_store_i(cmd_st),
    .bus_idle_i(bus_idle), .req_o(req), .req_addr_o(req_addr), .req_ch_o(req_ch),
    .req_transient_o(req_tr), .req_store_o(req_st), .gnt_i(gnt), .busy_o(busy));

  task automatic chk(input bit ok, input string r, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      finish_run();
    end
  end

  task automatic cmd(input logic [1:0] op, input logic [1:0] ch, input logic [31:0] a,
                     input logic [17:0] s, input logic [15:0] str, input logic tr, input logic st);
    @(negedge clk);
    cmd_valid = 1; cmd_op = op; cmd_ch = ch; cmd_addr = a; cmd_size = s;
    cmd_stride = str; cmd_tr = tr; cmd_st = st;
    @(posedge clk); #1;
    cmd_valid = 0; cmd_op = 0;
  endtask

  // one cycle: drive grant, sample combinational outputs, let the edge pass
  task automatic cycle(input logic g);
    @(negedge clk);
    gnt = g; #1;
    s_req = req; s_addr = req_addr; s_ch = req_ch; s_tr = req_tr; s_st = req_st;
    @(posedge clk); #1;
    gnt = 0;
  endtask

  initial begin
    int cnt;
    logic [31:0] ea;
    #(3*CLK_PERIOD);
    #1;
    chk(busy == 4'b0, "R1 busy after reset", 64'(busy), 0);
    chk(req == 1'b0, "R1 req after reset", 64'(req), 0);
    rst_n = 1;

    // table: single-stream walks, R3 and R4
    bus_idle = 1;
    for (int v = 0; v < NV; v++) begin
      cmd(2'd1, V_CH[v], V_ADDR[v], V_SIZE[v], V_STRIDE[v], 0, 0);
      cnt = 0;
      ea = V_ADDR[v];
      while (busy != 0 && cnt < 20) begin
        cycle(1);
        chk(s_req && s_addr == (ea & ~32'h1F), "R3 addr", 64'(s_addr), 64'(ea & ~32'h1F));
        chk(s_ch == V_CH[v], "R5 channel", 64'(s_ch), 64'(V_CH[v]));
        ea = ea + 32'(V_STRIDE[v]);
        cnt++;
      end
      chk(cnt == (int'(V_SIZE[v]) + 31) / 32, "R4 count", 64'(cnt), 64'((int'(V_SIZE[v]) + 31) / 32));
    end

    // R4 size zero
    cmd(2'd1, 2'd1, 32'h100, 18'd0, 16'd32, 0, 0);
    chk(busy == 0, "R4 size zero", 64'(busy), 0);

    // R4 oversized size limited to 4096 lines
    cmd(2'd1, 2'd0, 32'h0, 18'h3FFFF, 16'd32, 0, 0);
    cnt = 0;
    while (busy != 0 && cnt < 5000) begin cycle(1); cnt++; end
    chk(cnt == 4096, "R4 size limit", 64'(cnt), 4096);

    // R2 / R10: no request when bus busy, hold when not granted
    bus_idle = 0;
    cmd(2'd1, 2'd2, 32'h4000_0040, 18'd64, 16'd32, 1, 0);
    cycle(0);
    chk(s_req == 0, "R2 no req while bus busy", 64'(s_req), 0);
    bus_idle = 1;
    cycle(0);
    ea = s_addr;
    cycle(0);
    chk(s_req && s_addr == ea && s_ch == 2'd2, "R10 hold", 64'(s_addr), 64'(ea));
    chk(s_tr == 1 && s_st == 0, "R5 transient attr", 64'({s_tr, s_st}), 64'(2'b10));
    cmd(2'd3, 0, 0, 0, 0, 0, 0);

    // R5 store-intent
    cmd(2'd1, 2'd3, 32'h5000_0000, 18'd32, 16'd32, 0, 1);
    cycle(1);
    chk(s_ch == 2'd3 && s_tr == 0 && s_st == 1, "R5 store attr", 64'({s_ch, s_tr, s_st}), 64'({2'd3, 1'b0, 1'b1}));

    // R6 round robin across four streams; last grant was ch3 so start at 0
    bus_idle = 0;
    for (int c = 0; c < 4; c++) cmd(2'd1, 2'(c), 32'(c) << 12, 18'd1024, 16'd32, 0, 0);
    bus_idle = 1;
    for (int k = 0; k < 6; k++) begin
      cycle(1);
      chk(s_ch == 2'(k % 4), "R6 rotation", 64'(s_ch), 64'(k % 4));
    end

    // R7 stop one channel, others unaffected
    bus_idle = 0;
    cmd(2'd2, 2'd1, 0, 0, 0, 0, 0);
    chk(busy == 4'b1101, "R7 stop one", 64'(busy), 64'(4'b1101));

    // R8 stop all
    cmd(2'd3, 2'd0, 0, 0, 0, 0, 0);
    chk(busy == 4'b0000, "R8 stop all", 64'(busy), 0);

    // R9 restart a busy channel
    bus_idle = 1;
    cmd(2'd1, 2'd0, 32'h6000_0000, 18'd512, 16'd32, 0, 0);
    cycle(1);
    cycle(1);
    cmd(2'd1, 2'd0, 32'h7000_0025, 18'd64, 16'd32, 0, 0);
    cnt = 0;
    cycle(1);
    chk(s_addr == 32'h7000_0020, "R9 restart addr", 64'(s_addr), 64'h7000_0020);
    cnt++;
    while (busy != 0 && cnt < 20) begin cycle(1); cnt++; end
    chk(cnt == 2, "R9 restart count", 64'(cnt), 2);

    finish_run();
  end
endmodule